// File: doc/BRIEF.md
# I2C Target Address Recognition

This block runs the address phase of an I2C target port. After every START or repeated START it checks the incoming address bytes against a set of programmable own addresses and decides, for each byte, whether the port acknowledges in the ninth clock period. A bit-level receiver supplies it with whole bytes, each with a one-cycle valid pulse. Strobes for START, repeated START and STOP come from the same bit-level logic.

Each address slot holds a 10-bit address and a 10-bit mask of the same width. In a mask, a 1 bit means the matching address bit is not compared. Short (7-bit) addressing compares the upper seven bits of the first byte with the low seven address bits. In long (10-bit) addressing, the first byte must be a fixed five-bit prefix followed by the two high address bits. A second byte then supplies the low eight address bits. A general-call byte can also be accepted, under control of its own enable. The block reports the acknowledge decision, a selected flag, a general-call flag, the latched read/write bit and the index of the slot that was hit. The data-phase logic reads these outputs.

Top module: `i2c_addr_match`

## Requirements
- R1: While idle (after reset or STOP, with no START or repeated START since), `byte_vld_i` is ignored: `ack_vld_o` stays 0 and every other output keeps its value.
- R2: For a byte accepted in the address phase, `ack_vld_o` is 1 in the cycle after `byte_vld_i`. `ack_o` then holds the decision (1 = ACK, drive SDA low; 0 = NACK) until the next address decision or strobe. Every strobe returns `ack_o` to 0.
- R3: With `ten_bit_en_i` = 0, a first byte matches slot k when byte bits [7:1] equal address bits [6:0] of slot k at every position where mask bit [6:0] is 0.
- R4: A first byte whose bits [7:1] are all zero is acknowledged when `gc_en_i` = 1, and `gc_hit_o` is set. When `gc_en_i` = 0, that byte is acknowledged only if a slot matches it under R3.
- R5: With `ten_bit_en_i` = 1, a first byte is acknowledged when bits [7:3] equal 11110 and bits [2:1] equal address bits [9:8] of some slot (masked as in R3). `selected_o` stays 0 while the block waits for the second byte.
- R6: The second byte of a long address is compared with address bits [7:0] (masked), but only on slots that matched the first byte. A match gives ACK with `selected_o` = 1. A mismatch gives NACK with `selected_o` = 0.
- R7: After a NACK, further bytes give no `ack_vld_o` and change no output until the next START or repeated START.
- R8: `selected_o` becomes 1 when a short, general-call or long match completes. It is cleared, together with `gc_hit_o`, `rw_o`, `slot_hit_o` and `ack_o`, in the cycle after any START, repeated START or STOP.
- R9: `rw_o` takes bit 0 of the first address byte when that byte is acknowledged. It is cleared if a long address is later rejected.
- R10: When several slots match, `slot_hit_o` reports the lowest-numbered one. For a general call matched by no slot, it reports 0.
- R11: Once the block is selected, further bytes are data: `ack_vld_o` stays 0 and all outputs hold.
- R12: A strobe that arrives in the same cycle as `byte_vld_i` takes precedence, and the byte is dropped. STOP takes precedence over START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | START condition strobe |
| rstart_i | input | 1 | Repeated START strobe |
| stop_i | input | 1 | STOP condition strobe |
| byte_vld_i | input | 1 | One-cycle pulse: `byte_i` holds a received byte |
| byte_i | input | 8 | Received byte, MSB first on the wire |
| own_addr_i | input | NUM_SLOTS*10 | Own address per slot, slot 0 in the low bits |
| own_mask_i | input | NUM_SLOTS*10 | Don't-care mask per slot, 1 = ignore bit |
| gc_en_i | input | 1 | Accept general-call byte |
| ten_bit_en_i | input | 1 | Long (10-bit) addressing |
| ack_vld_o | output | 1 | Address decision made this cycle |
| ack_o | output | 1 | Current decision, 1 = ACK |
| selected_o | output | 1 | Port addressed since last strobe |
| gc_hit_o | output | 1 | Selection came from general call |
| rw_o | output | 1 | Latched read/write bit |
| slot_hit_o | output | SLOT_W | Index of the matched slot |

## Verification
The hardest situation to reach is a long address in which both slots pass the first-byte test but only the higher slot passes the second-byte test. It shows whether the candidate set from the first byte is carried forward and whether the priority is applied after the second compare. The random address generator builds most bytes from the currently programmed slot addresses: the exact short form, the long-prefix form, or the low byte. The two slots often share their high bits, and the masks are sparse. Directed sequences set up this case on purpose, along with a STOP that coincides with a byte and a general call that a slot also matches.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
   localparam int unsigned AM_ADDR_W = 10;
   localparam logic [4:0]  AM_LONG_PREFIX = 5'b11110;

   typedef enum logic [2:0] {
      AM_IDLE,
      AM_FIRST,
      AM_SECOND,
      AM_CHOSEN,
      AM_REJECT
   } am_state_e;
endpackage

// File: rtl/i2c_am_slot.sv
module i2c_am_slot
   import i2c_am_pkg::*;
(
   input  logic [AM_ADDR_W-1:0] own_addr,
   input  logic [AM_ADDR_W-1:0] own_mask,
   input  logic [7:0]           rx_byte,
   output logic                 hit_short,
   output logic                 hit_long_hi,
   output logic                 hit_long_lo
);
   logic [6:0] diff_short;
   logic [1:0] diff_hi;
   logic [7:0] diff_lo;

   always_comb begin
      diff_short  = (rx_byte[7:1] ^ own_addr[6:0]) & ~own_mask[6:0];
      diff_hi     = (rx_byte[2:1] ^ own_addr[9:8]) & ~own_mask[9:8];
      diff_lo     = (rx_byte      ^ own_addr[7:0]) & ~own_mask[7:0];
      hit_short   = (diff_short == '0);
      hit_long_hi = (rx_byte[7:3] == AM_LONG_PREFIX) && (diff_hi == '0);
      hit_long_lo = (diff_lo == '0);
   end
endmodule

// File: rtl/i2c_am_pick.sv
module i2c_am_pick #(
   parameter int unsigned N = 2,
   parameter int unsigned W = 1
) (
   input  logic [N-1:0] req,
   output logic         any,
   output logic [W-1:0] idx
);
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = W'(i);
      end
   end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
   import i2c_am_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 2,
   localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
   localparam int unsigned CFG_W  = NUM_SLOTS * AM_ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              rstart_i,
   input  logic              stop_i,
   input  logic              byte_vld_i,
   input  logic [7:0]        byte_i,
   input  logic [CFG_W-1:0]  own_addr_i,
   input  logic [CFG_W-1:0]  own_mask_i,
   input  logic              gc_en_i,
   input  logic              ten_bit_en_i,
   output logic              ack_vld_o,
   output logic              ack_o,
   output logic              selected_o,
   output logic              gc_hit_o,
   output logic              rw_o,
   output logic [SLOT_W-1:0] slot_hit_o
);
   generate
      if (NUM_SLOTS < 1 || NUM_SLOTS > 16) begin : g_bad_slots
         $error("i2c_addr_match: NUM_SLOTS must be 1..16");
      end
   endgenerate

   am_state_e            state_q;
   logic [NUM_SLOTS-1:0] hs, hh, hl, cand_q, pick_req;
   logic                 pick_any, gc_ok, start_any;
   logic [SLOT_W-1:0]    pick_idx;

   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      i2c_am_slot u_slot (
         .own_addr    (own_addr_i[k*AM_ADDR_W +: AM_ADDR_W]),
         .own_mask    (own_mask_i[k*AM_ADDR_W +: AM_ADDR_W]),
         .rx_byte     (byte_i),
         .hit_short   (hs[k]),
         .hit_long_hi (hh[k]),
         .hit_long_lo (hl[k])
      );
   end

   always_comb begin
      start_any = start_i | rstart_i;
      gc_ok     = gc_en_i && (byte_i[7:1] == 7'd0);
      if (state_q == AM_SECOND) pick_req = cand_q & hl;
      else if (ten_bit_en_i)    pick_req = hh;
      else                      pick_req = hs;
   end

   i2c_am_pick #(.N(NUM_SLOTS), .W(SLOT_W)) u_pick (
      .req (pick_req),
      .any (pick_any),
      .idx (pick_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= AM_IDLE;
         ack_vld_o  <= 1'b0;
         ack_o      <= 1'b0;
         selected_o <= 1'b0;
         gc_hit_o   <= 1'b0;
         rw_o       <= 1'b0;
         slot_hit_o <= '0;
         cand_q     <= '0;
      end else begin
         ack_vld_o <= 1'b0;
         if (stop_i || start_any) begin
            state_q    <= stop_i ? AM_IDLE : AM_FIRST;
            ack_o      <= 1'b0;
            selected_o <= 1'b0;
            gc_hit_o   <= 1'b0;
            rw_o       <= 1'b0;
            slot_hit_o <= '0;
            cand_q     <= '0;
         end else if (byte_vld_i) begin
            unique case (state_q)
               AM_FIRST: begin
                  ack_vld_o <= 1'b1;
                  if (ten_bit_en_i && pick_any) begin
                     ack_o   <= 1'b1;
                     cand_q  <= hh;
                     rw_o    <= byte_i[0];
                     state_q <= AM_SECOND;
                  end else if ((!ten_bit_en_i && pick_any) || gc_ok) begin
                     ack_o      <= 1'b1;
                     selected_o <= 1'b1;
                     gc_hit_o   <= gc_ok;
                     rw_o       <= byte_i[0];
                     slot_hit_o <= (!ten_bit_en_i && pick_any) ? pick_idx : '0;
                     state_q    <= AM_CHOSEN;
                  end else begin
                     ack_o   <= 1'b0;
                     state_q <= AM_REJECT;
                  end
               end
               AM_SECOND: begin
                  ack_vld_o <= 1'b1;
                  if (pick_any) begin
                     ack_o      <= 1'b1;
                     selected_o <= 1'b1;
                     slot_hit_o <= pick_idx;
                     state_q    <= AM_CHOSEN;
                  end else begin
                     ack_o   <= 1'b0;
                     rw_o    <= 1'b0;
                     cand_q  <= '0;
                     state_q <= AM_REJECT;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assert_strobe_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i | rstart_i | stop_i) |=> (!selected_o && !gc_hit_o && !ack_o));

   assert_decision_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vld_o |-> $past(byte_vld_i));

   assert_idle_ignores_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == AM_IDLE && !start_any) |=> !ack_vld_o);

   assert_reject_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == AM_REJECT && !start_any && !stop_i) |=> (!ack_vld_o && !selected_o));

   assert_select_acked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(selected_o) |-> (ack_o && ack_vld_o));

   assert_gc_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
      gc_hit_o |-> selected_o);

   assert_data_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == AM_CHOSEN && !start_any && !stop_i) |=> (!ack_vld_o && $stable(selected_o)));
endmodule

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 0, rstart_i = 0, stop_i = 0, byte_vld_i = 0;
   logic [7:0] byte_i = 8'h00;
   logic [9:0] cfg_addr [2];
   logic [9:0] cfg_mask [2];
   logic gc_en_i = 0, ten_bit_en_i = 0;
   logic ack_vld_o, ack_o, selected_o, gc_hit_o, rw_o;
   logic [0:0] slot_hit_o;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   i2c_addr_match i_i2c_addr_match (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rstart_i(rstart_i), .stop_i(stop_i),
      .byte_vld_i(byte_vld_i), .byte_i(byte_i),
      .own_addr_i({cfg_addr[1], cfg_addr[0]}), .own_mask_i({cfg_mask[1], cfg_mask[0]}),
      .gc_en_i(gc_en_i), .ten_bit_en_i(ten_bit_en_i),
      .ack_vld_o(ack_vld_o), .ack_o(ack_o), .selected_o(selected_o),
      .gc_hit_o(gc_hit_o), .rw_o(rw_o), .slot_hit_o(slot_hit_o));

   // reference model state: 0 idle, 1 first byte, 2 second byte, 3 chosen, 4 rejected
   int m_st = 0, m_slot = 0;
   bit m_vld = 0, m_ack = 0, m_sel = 0, m_gc = 0, m_rw = 0;
   bit [1:0] m_cand = 0;

   function automatic bit f_short(int k, logic [7:0] b);
      return ((b[7:1] ^ cfg_addr[k][6:0]) & ~cfg_mask[k][6:0]) == 7'd0;
   endfunction
   function automatic bit f_hi(int k, logic [7:0] b);
      return (b[7:3] == 5'b11110) && (((b[2:1] ^ cfg_addr[k][9:8]) & ~cfg_mask[k][9:8]) == 2'd0);
   endfunction
   function automatic bit f_lo(int k, logic [7:0] b);
      return ((b ^ cfg_addr[k][7:0]) & ~cfg_mask[k][7:0]) == 8'd0;
   endfunction

   task automatic m_clear();
      m_ack = 0; m_sel = 0; m_gc = 0; m_rw = 0; m_slot = 0; m_cand = 0;
   endtask

   task automatic model(bit st, bit rs, bit sp, bit bv, logic [7:0] b);
      bit [1:0] vs, vh, vl;
      bit g;
      m_vld = 0;
      for (int k = 0; k < 2; k++) begin
         vs[k] = f_short(k, b); vh[k] = f_hi(k, b); vl[k] = f_lo(k, b);
      end
      g = gc_en_i && (b[7:1] == 7'd0);
      if (sp) begin m_st = 0; m_clear(); end
      else if (st || rs) begin m_st = 1; m_clear(); end
      else if (bv && m_st == 1) begin
         m_vld = 1;
         if (ten_bit_en_i && vh != 0) begin
            m_ack = 1; m_cand = vh; m_rw = b[0]; m_st = 2;
         end else if ((!ten_bit_en_i && vs != 0) || g) begin
            m_ack = 1; m_sel = 1; m_gc = g; m_rw = b[0];
            m_slot = (!ten_bit_en_i && vs != 0) ? (vs[0] ? 0 : 1) : 0;
            m_st = 3;
         end else begin
            m_ack = 0; m_st = 4;
         end
      end else if (bv && m_st == 2) begin
         m_vld = 1;
         if ((m_cand & vl) != 0) begin
            m_ack = 1; m_sel = 1; m_slot = (m_cand[0] & vl[0]) ? 0 : 1; m_st = 3;
         end else begin
            m_ack = 0; m_rw = 0; m_cand = 0; m_st = 4;
         end
      end
   endtask

   task automatic check(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(string ctx);
      check({ctx, "/R2"}, "ack_vld_o", int'(ack_vld_o), int'(m_vld));
      check({ctx, "/R2"}, "ack_o", int'(ack_o), int'(m_ack));
      check({ctx, "/R8"}, "selected_o", int'(selected_o), int'(m_sel));
      check({ctx, "/R4"}, "gc_hit_o", int'(gc_hit_o), int'(m_gc));
      check({ctx, "/R9"}, "rw_o", int'(rw_o), int'(m_rw));
      check({ctx, "/R10"}, "slot_hit_o", int'(slot_hit_o), m_slot);
   endtask

   // drive at a falling edge, let one rising edge pass, check at the next falling edge
   task automatic ev(string ctx, bit st, bit rs, bit sp, bit bv, logic [7:0] b);
      start_i = st; rstart_i = rs; stop_i = sp; byte_vld_i = bv; byte_i = b;
      model(st, rs, sp, bv, b);
      @(negedge clk);
      start_i = 0; rstart_i = 0; stop_i = 0; byte_vld_i = 0;
      check_all(ctx);
   endtask

   task automatic cfg(logic [9:0] a0, logic [9:0] k0, logic [9:0] a1, logic [9:0] k1, bit gc, bit ten);
      cfg_addr[0] = a0; cfg_mask[0] = k0; cfg_addr[1] = a1; cfg_mask[1] = k1;
      gc_en_i = gc; ten_bit_en_i = ten;
   endtask

   function automatic logic [7:0] pick_byte();
      int r = $urandom_range(0, 99);
      int k = $urandom_range(0, 1);
      if (r < 25) return {cfg_addr[k][6:0], 1'($urandom_range(0, 1))};
      if (r < 45) return {5'b11110, cfg_addr[k][9:8], 1'($urandom_range(0, 1))};
      if (r < 65) return cfg_addr[k][7:0];
      if (r < 75) return 8'($urandom_range(0, 1));
      return 8'($urandom_range(0, 255));
   endfunction

   initial begin
      #2_000_000;
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1c2a));
      cfg(10'h052, 10'h000, 10'h13a, 10'h000, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      check_all("reset");
      rst_n = 1'b1;
      @(negedge clk);

      // R1: byte while idle is ignored
      ev("R1", 0, 0, 0, 1, 8'hA4);
      // R3: short address exact match on slot 0, read bit set
      ev("R3", 1, 0, 0, 0, 8'h00);
      ev("R3", 0, 0, 0, 1, 8'hA5);
      // R11: data byte after selection changes nothing
      ev("R11", 0, 0, 0, 1, 8'h00);
      // R12: rstart with a byte in the same cycle drops the byte
      ev("R12", 0, 1, 0, 1, 8'hA4);
      // R3: masked bits are don't-care, slot 1 only
      cfg(10'h052, 10'h000, 10'h13a, 10'h00f, 1'b0, 1'b0);
      ev("R3", 0, 0, 0, 1, 8'h70);
      // R4: general call disabled and no slot match -> NACK, R7 then ignore
      ev("R4", 0, 0, 0, 0, 8'h00);
      ev("R4", 1, 0, 0, 0, 8'h00);
      ev("R4", 0, 0, 0, 1, 8'h00);
      ev("R7", 0, 0, 0, 1, 8'hA4);
      // R4: general call enabled
      gc_en_i = 1'b1;
      ev("R4", 0, 1, 0, 0, 8'h00);
      ev("R4", 0, 0, 0, 1, 8'h00);
      // R10: both slots match the same short address -> slot 0
      cfg(10'h033, 10'h000, 10'h233, 10'h000, 1'b0, 1'b0);
      ev("R10", 0, 1, 0, 0, 8'h00);
      ev("R10", 0, 0, 0, 1, 8'h66);
      // R5/R6: long address, both slots pass first byte, only slot 1 passes second
      cfg(10'h2c1, 10'h000, 10'h2c7, 10'h000, 1'b0, 1'b1);
      ev("R5", 0, 0, 1, 0, 8'h00);
      ev("R5", 1, 0, 0, 0, 8'h00);
      ev("R5", 0, 0, 0, 1, 8'hF4);
      ev("R6", 0, 0, 0, 1, 8'hC7);
      // R6/R7/R9: second byte miss clears rw, then ignore
      ev("R6", 0, 1, 0, 0, 8'h00);
      ev("R6", 0, 0, 0, 1, 8'hF5);
      ev("R6", 0, 0, 0, 1, 8'h11);
      ev("R7", 0, 0, 0, 1, 8'hC1);
      // R12: STOP beats START and byte
      ev("R12", 1, 0, 1, 1, 8'hF4);
      ev("R1", 0, 0, 0, 1, 8'hF4);

      // random mix
      for (int n = 0; n < 3000; n++) begin
         int r = $urandom_range(0, 99);
         if (n % 150 == 0)
            cfg(10'($urandom_range(0, 1023)), 10'($urandom_range(0, 3) == 0 ? $urandom_range(0, 1023) & 10'h111 : 0),
                10'($urandom_range(0, 1023)), 10'($urandom_range(0, 3) == 0 ? $urandom_range(0, 1023) & 10'h088 : 0),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
         if (n % 150 == 1 && $urandom_range(0, 1) == 1) cfg_addr[1][9:8] = cfg_addr[0][9:8];
         if (r < 6)       ev("rnd", 0, 0, 1, $urandom_range(0, 3) == 0, pick_byte());
         else if (r < 16) ev("rnd", 1, 0, 0, $urandom_range(0, 3) == 0, pick_byte());
         else if (r < 24) ev("rnd", 0, 1, 0, 0, 8'h00);
         else             ev("rnd", 0, 0, 0, 1, pick_byte());
      end

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule